// File: doc/BRIEF.md
# Dual-Channel Command Merge Selector

This block sits behind a processor core that issues requests on two independent Wishbone master channels, one for instruction fetches and one for data accesses, and funnels them into a single outbound command path. Each channel's request is captured into a one-entry holding slot as a fixed 78-bit command word. A selector then decides which held word drives the single output.

The selector prefers the data slot when both slots fill at the same time. Once it has chosen a slot, that choice is held for as long as the chosen slot stays full, so the outbound command never changes in the middle of being consumed. The consumer frees a slot by pulsing that slot's bit of a taken vector. Both bits may be pulsed in the same cycle. Response routing and more than one outstanding command per channel are handled elsewhere.

The two inbound channels have no back-pressure pin. A request that arrives while its slot is full is dropped, so the core must keep a request pending until the slot is free. On the outbound side, the consumer acknowledges a word by pulsing the taken bit of the slot named on `cmd_entry`.

Top module: `cmdsel_top`

## Requirements
- R1: The command word places the extended code in bits 7:0, write data in bits 39:8, address in bits 71:40, byte selects in bits 75:72, the write-enable flag in bit 76 and the valid flag in bit 77.
- R2: A channel presents a request only in a cycle where both its cyc and its stb are 1. With only one of the two high, nothing is captured.
- R3: A word captured from the instruction channel has write enable 0, byte selects 0 and write data 0. Its address is the 30-bit word address followed by two zero bits.
- R4: An empty slot captures a request on the clock edge where the request is present. A full slot ignores new requests until it is taken, and keeps its original word.
- R5: Bit 0 of `taken` empties the instruction slot and bit 1 empties the data slot on the next edge. Both bits may be set together. A taken bit for an empty slot has no effect, and that slot still captures a request present in the same cycle.
- R6: When both slots hold a command and no choice is being held, the data slot drives the output. `cmd_entry` is 1 for the data slot and 0 for the instruction slot.
- R7: A choice made in one cycle is kept in later cycles for as long as the chosen slot stays full, even if the other slot fills.
- R8: When neither slot is full, `cmd_out` is all zeros and `cmd_entry` is 0.
- R9: An active-low reset empties both slots and drops any held choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_cyc | input | 1 | Instruction channel cycle |
| ins_stb | input | 1 | Instruction channel strobe |
| ins_adr | input | 30 | Instruction word address |
| dat_cyc | input | 1 | Data channel cycle |
| dat_stb | input | 1 | Data channel strobe |
| dat_we | input | 1 | Data channel write enable |
| dat_sel | input | 4 | Data channel byte selects |
| dat_adr | input | 32 | Data channel byte address |
| dat_wdata | input | 32 | Data channel write data |
| ext_code | input | 8 | Extended command code, captured with whichever slot fills |
| taken | input | 2 | Per-slot free pulse (bit 0 instruction, bit 1 data) |
| cmd_out | output | 78 | Selected command word |
| cmd_entry | output | 1 | Slot driving `cmd_out` (0 instruction, 1 data) |

## Verification
The properties assume the following about the inputs: they change only away from the rising edge, reset is the only asynchronous control, and any pattern of `taken` may occur, including bits for empty slots. The sticky-choice and hold properties rely on the consumer leaving the chosen slot's taken bit low while it waits. The stimulus follows this rule: it pulses a taken bit only for the slot named on `cmd_entry`, except in the cases that deliberately pulse both bits or pulse the bit of an empty slot. Every input is driven on the falling edge and released one cycle later.

// File: rtl/cmdsel_pkg.sv
package cmdsel_pkg;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_SEL_W  = 4;
  localparam int unsigned DEF_EXT_W  = 8;
  localparam int unsigned NUM_ENT    = 2;

  typedef enum logic {
    ENT_INSTR = 1'b0,
    ENT_DATA  = 1'b1
  } ent_e;
endpackage

// File: rtl/cmdsel_pack.sv
// Builds one command word from a channel's request signals.
module cmdsel_pack #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned EXT_W  = 8,
  localparam int unsigned CMD_W = 2 + SEL_W + ADDR_W + DATA_W + EXT_W
) (
  input  logic              cyc,
  input  logic              stb,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] adr,
  input  logic [DATA_W-1:0] wdat,
  input  logic [EXT_W-1:0]  ext,
  output logic              req,
  output logic [CMD_W-1:0]  word
);
  localparam int unsigned DAT_LO = EXT_W;
  localparam int unsigned ADR_LO = DAT_LO + DATA_W;
  localparam int unsigned SEL_LO = ADR_LO + ADDR_W;
  localparam int unsigned WE_BIT = SEL_LO + SEL_W;
  localparam int unsigned VL_BIT = WE_BIT + 1;

  always_comb begin
    req                          = cyc & stb;
    word                         = '0;
    word[VL_BIT]                 = req;
    word[WE_BIT]                 = we;
    word[SEL_LO +: SEL_W]        = sel;
    word[ADR_LO +: ADDR_W]       = adr;
    word[DAT_LO +: DATA_W]       = wdat;
    word[0 +: EXT_W]             = ext;
  end
endmodule

// File: rtl/cmdsel_slot.sv
// One-entry command holding slot.
module cmdsel_slot #(
  parameter int unsigned CMD_W = 78
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CMD_W-1:0] word_in,
  input  logic             take,
  output logic             vld,
  output logic [CMD_W-1:0] word
);
  logic [CMD_W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (held_q[CMD_W-1]) begin
      if (take) held_q <= '0;
    end else if (req) begin
      held_q <= word_in;
    end
  end

  assign vld  = held_q[CMD_W-1];
  assign word = held_q;
endmodule

// File: rtl/cmdsel_arb.sv
// Sticky selector: the highest index wins a fresh choice, and a held choice persists.
module cmdsel_arb #(
  parameter int unsigned NENT = 2,
  localparam int unsigned IDX_W = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NENT-1:0]  ent_vld,
  output logic             any,
  output logic [IDX_W-1:0] pick,
  output logic             hold_v,
  output logic [IDX_W-1:0] hold_idx
);
  logic [IDX_W-1:0] fresh;

  always_comb begin
    fresh = '0;
    for (int k = 0; k < NENT; k++) begin
      if (ent_vld[k]) fresh = IDX_W'(k);
    end
  end

  assign any  = |ent_vld;
  assign pick = (hold_v && ent_vld[hold_idx]) ? hold_idx : fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v   <= 1'b0;
      hold_idx <= '0;
    end else begin
      hold_v   <= any;
      hold_idx <= any ? pick : '0;
    end
  end
endmodule

// File: rtl/cmdsel_top.sv
module cmdsel_top
  import cmdsel_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned SEL_W  = DEF_SEL_W,
  parameter int unsigned EXT_W  = DEF_EXT_W,
  localparam int unsigned CMD_W = 2 + SEL_W + ADDR_W + DATA_W + EXT_W,
  localparam int unsigned IAD_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_cyc,
  input  logic              ins_stb,
  input  logic [IAD_W-1:0]  ins_adr,
  input  logic              dat_cyc,
  input  logic              dat_stb,
  input  logic              dat_we,
  input  logic [SEL_W-1:0]  dat_sel,
  input  logic [ADDR_W-1:0] dat_adr,
  input  logic [DATA_W-1:0] dat_wdata,
  input  logic [EXT_W-1:0]  ext_code,
  input  logic [1:0]        taken,
  output logic [CMD_W-1:0]  cmd_out,
  output logic              cmd_entry
);
  logic              ch_cyc  [NUM_ENT];
  logic              ch_stb  [NUM_ENT];
  logic              ch_we   [NUM_ENT];
  logic [SEL_W-1:0]  ch_sel  [NUM_ENT];
  logic [ADDR_W-1:0] ch_adr  [NUM_ENT];
  logic [DATA_W-1:0] ch_wdat [NUM_ENT];
  logic              ch_req  [NUM_ENT];
  logic [CMD_W-1:0]  ch_word [NUM_ENT];
  logic [CMD_W-1:0]  ent_word[NUM_ENT];
  logic [NUM_ENT-1:0] ent_vld;

  logic any_vld;
  logic pick;
  logic hold_v;
  logic hold_idx;

  // Instruction channel: fetch only, word-aligned address.
  assign ch_cyc [ENT_INSTR] = ins_cyc;
  assign ch_stb [ENT_INSTR] = ins_stb;
  assign ch_we  [ENT_INSTR] = 1'b0;
  assign ch_sel [ENT_INSTR] = '0;
  assign ch_adr [ENT_INSTR] = {ins_adr, 2'b00};
  assign ch_wdat[ENT_INSTR] = '0;

  assign ch_cyc [ENT_DATA]  = dat_cyc;
  assign ch_stb [ENT_DATA]  = dat_stb;
  assign ch_we  [ENT_DATA]  = dat_we;
  assign ch_sel [ENT_DATA]  = dat_sel;
  assign ch_adr [ENT_DATA]  = dat_adr;
  assign ch_wdat[ENT_DATA]  = dat_wdata;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    cmdsel_pack #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .EXT_W(EXT_W)
    ) u_pack (
      .cyc (ch_cyc[g]),
      .stb (ch_stb[g]),
      .we  (ch_we[g]),
      .sel (ch_sel[g]),
      .adr (ch_adr[g]),
      .wdat(ch_wdat[g]),
      .ext (ext_code),
      .req (ch_req[g]),
      .word(ch_word[g])
    );

    cmdsel_slot #(.CMD_W(CMD_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (ch_req[g]),
      .word_in(ch_word[g]),
      .take   (taken[g]),
      .vld    (ent_vld[g]),
      .word   (ent_word[g])
    );
  end

  cmdsel_arb #(.NENT(NUM_ENT)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .ent_vld (ent_vld),
    .any     (any_vld),
    .pick    (pick),
    .hold_v  (hold_v),
    .hold_idx(hold_idx)
  );

  assign cmd_out   = any_vld ? ent_word[pick] : '0;
  assign cmd_entry = any_vld ? pick : 1'b0;
endmodule

// File: rtl/cmdsel_chk.sv
module cmdsel_chk #(
  parameter int unsigned CMD_W = 78
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_cyc,
  input logic             ins_stb,
  input logic             dat_cyc,
  input logic             dat_stb,
  input logic [1:0]       taken,
  input logic [CMD_W-1:0] cmd_out,
  input logic             cmd_entry,
  input logic [1:0]       ent_vld,
  input logic             hold_v
);
  localparam int unsigned VL_BIT = CMD_W - 1;
  localparam int unsigned WE_BIT = CMD_W - 2;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_vld == 2'b00) |-> (cmd_out == '0 && !cmd_entry)); // R8

  AST_DATA_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_vld == 2'b11 && !hold_v) |-> cmd_entry); // R6

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out[VL_BIT] && !taken[cmd_entry]) |=> (cmd_out[VL_BIT] && cmd_entry == $past(cmd_entry) && cmd_out == $past(cmd_out))); // R7

  AST_TAKE_INS: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_vld[0] && taken[0]) |=> !ent_vld[0]); // R5

  AST_TAKE_DAT: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_vld[1] && taken[1]) |=> !ent_vld[1]); // R5

  AST_CAPTURE_INS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ent_vld[0] && ins_cyc && ins_stb) |=> ent_vld[0]); // R4

  AST_CAPTURE_DAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ent_vld[1] && dat_cyc && dat_stb) |=> ent_vld[1]); // R4

  AST_NO_STRAY_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ent_vld[1] && !(dat_cyc && dat_stb)) |=> !ent_vld[1]); // R2

  AST_INS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out[VL_BIT] && !cmd_entry) |-> !cmd_out[WE_BIT]); // R3
endmodule

bind cmdsel_top cmdsel_chk #(.CMD_W(CMD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ins_cyc  (ins_cyc),
  .ins_stb  (ins_stb),
  .dat_cyc  (dat_cyc),
  .dat_stb  (dat_stb),
  .taken    (taken),
  .cmd_out  (cmd_out),
  .cmd_entry(cmd_entry),
  .ent_vld  (ent_vld),
  .hold_v   (hold_v)
);

// File: tb/tb_cmdsel_top.sv
module tb_cmdsel_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ins_cyc, ins_stb;
  logic [29:0] ins_adr;
  logic        dat_cyc, dat_stb, dat_we;
  logic [3:0]  dat_sel;
  logic [31:0] dat_adr, dat_wdata;
  logic [7:0]  ext_code;
  logic [1:0]  taken;
  logic [77:0] cmd_out;
  logic        cmd_entry;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [77:0] exp_word[$];
  logic        exp_ent[$];

  always #2 clk = ~clk;

  cmdsel_top dut (
    .clk(clk), .rst_n(rst_n),
    .ins_cyc(ins_cyc), .ins_stb(ins_stb), .ins_adr(ins_adr),
    .dat_cyc(dat_cyc), .dat_stb(dat_stb), .dat_we(dat_we),
    .dat_sel(dat_sel), .dat_adr(dat_adr), .dat_wdata(dat_wdata),
    .ext_code(ext_code), .taken(taken),
    .cmd_out(cmd_out), .cmd_entry(cmd_entry)
  );

  // Expected word per R1: {valid, we, sel, adr, wdata, ext}.
  function automatic logic [77:0] mk(logic we, logic [3:0] sel, logic [31:0] adr,
                                     logic [31:0] wd, logic [7:0] ext);
    return {1'b1, we, sel, adr, wd, ext};
  endfunction

  task automatic chk(bit ok, string tag, logic [77:0] act, logic [77:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_in();
    ins_cyc = 0; ins_stb = 0; dat_cyc = 0; dat_stb = 0; taken = 2'b00;
  endtask

  task automatic drv_ins(logic [29:0] a, logic [7:0] e);
    ins_cyc = 1; ins_stb = 1; ins_adr = a; ext_code = e;
  endtask

  task automatic drv_dat(logic we, logic [3:0] s, logic [31:0] a, logic [31:0] d, logic [7:0] e);
    dat_cyc = 1; dat_stb = 1; dat_we = we; dat_sel = s; dat_adr = a; dat_wdata = d; ext_code = e;
  endtask

  task automatic push(logic [77:0] w, logic ent);
    exp_word.push_back(w);
    exp_ent.push_back(ent);
  endtask

  // Monitor: compares the output with the scoreboard head and then consumes it.
  task automatic serve(string tag);
    logic [77:0] w;
    logic        e;
    w = exp_word.pop_front();
    e = exp_ent.pop_front();
    chk(cmd_out == w, {tag, " word"}, cmd_out, w);
    chk(cmd_entry == e, {tag, " entry"}, 78'(cmd_entry), 78'(e));
    taken = e ? 2'b10 : 2'b01;
    tick();
    taken = 2'b00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle_in(); ins_adr = '0; dat_we = 0; dat_sel = '0;
    dat_adr = '0; dat_wdata = '0; ext_code = '0;
    repeat (3) tick();
    chk(cmd_out == '0 && !cmd_entry, "R9 reset state", cmd_out, '0);
    rst_n = 1;
    tick();

    // R3 / R1: instruction only
    drv_ins(30'h1234567, 8'h5A);
    push(mk(1'b0, 4'h0, {30'h1234567, 2'b00}, 32'h0, 8'h5A), 1'b0);
    tick(); idle_in();
    serve("R3 instr fields");
    chk(cmd_out == '0 && !cmd_entry, "R8 idle after take", cmd_out, '0);

    // R1: data write, field positions
    drv_dat(1'b1, 4'b1010, 32'hDEAD_BEE0, 32'h0123_4567, 8'hC3);
    push(mk(1'b1, 4'b1010, 32'hDEAD_BEE0, 32'h0123_4567, 8'hC3), 1'b1);
    tick(); idle_in();
    serve("R1 data layout");

    // R2: cyc without stb, stb without cyc
    dat_cyc = 1; ins_stb = 1; tick(); idle_in();
    chk(cmd_out == '0, "R2 partial strobe ignored", cmd_out, '0);
    dat_stb = 1; ins_cyc = 1; tick(); idle_in();
    chk(cmd_out == '0, "R2 partial cyc ignored", cmd_out, '0);

    // R6: simultaneous arrival, data first
    drv_ins(30'h0000ABC, 8'h11);
    drv_dat(1'b0, 4'b1111, 32'h0000_1000, 32'h0, 8'h11);
    push(mk(1'b0, 4'b1111, 32'h0000_1000, 32'h0, 8'h11), 1'b1);
    push(mk(1'b0, 4'h0, {30'h0000ABC, 2'b00}, 32'h0, 8'h11), 1'b0);
    tick(); idle_in();
    serve("R6 data wins tie");
    serve("R6 instr after data");

    // R7: instruction held while data arrives
    drv_ins(30'h3FFFFFF, 8'h22); tick(); idle_in();
    drv_dat(1'b1, 4'b0001, 32'h8000_0004, 32'hCAFE_F00D, 8'h33); tick(); idle_in();
    chk(cmd_entry == 1'b0, "R7 held on instr", 78'(cmd_entry), 78'(0));
    tick();
    chk(cmd_entry == 1'b0, "R7 still held", 78'(cmd_entry), 78'(0));
    push(mk(1'b0, 4'h0, {30'h3FFFFFF, 2'b00}, 32'h0, 8'h22), 1'b0);
    push(mk(1'b1, 4'b0001, 32'h8000_0004, 32'hCAFE_F00D, 8'h33), 1'b1);
    serve("R7 held word");
    serve("R7 data after release");

    // R4: full slot ignores a second request
    drv_dat(1'b1, 4'b0011, 32'h0000_0040, 32'h1111_2222, 8'h44); tick(); idle_in();
    drv_dat(1'b0, 4'b1100, 32'h0000_0080, 32'h3333_4444, 8'h55); tick(); idle_in();
    push(mk(1'b1, 4'b0011, 32'h0000_0040, 32'h1111_2222, 8'h44), 1'b1);
    serve("R4 first word kept");
    chk(cmd_out == '0, "R4 second dropped", cmd_out, '0);

    // R5: both taken together
    drv_ins(30'h0000001, 8'h66);
    drv_dat(1'b0, 4'b0100, 32'h0000_0100, 32'h0, 8'h66);
    tick(); idle_in();
    chk(cmd_out[77] == 1'b1, "R5 both full", cmd_out, mk(0, 0, 0, 0, 0));
    taken = 2'b11; tick(); taken = 2'b00;
    chk(cmd_out == '0, "R5 dual take clears", cmd_out, '0);

    // R5: taken on empty slot with a concurrent request
    taken = 2'b01; drv_ins(30'h0000777, 8'h77); tick(); idle_in();
    push(mk(1'b0, 4'h0, {30'h0000777, 2'b00}, 32'h0, 8'h77), 1'b0);
    serve("R5 take on empty ignored");

    // R9: reset with both slots full
    drv_ins(30'h0000002, 8'h88);
    drv_dat(1'b1, 4'hF, 32'h0000_0200, 32'hFFFF_FFFF, 8'h88);
    tick(); idle_in();
    rst_n = 0; tick();
    chk(cmd_out == '0, "R9 reset clears slots", cmd_out, '0);
    rst_n = 1; tick();
    chk(cmd_out == '0 && !cmd_entry, "R9 empty after reset", cmd_out, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule